// File: doc/BRIEF.md
# Little-Endian Byte and Word Memory Port

This block connects a 16-bit register datapath to a memory that is addressed in bytes but built from 16-bit words. A request carries a byte address, an access size (byte or word), a direction and write data. The block turns it into a word index, per-lane byte enables and lane-steered write data for the memory. It formats the memory's read word into a register value and returns it with a valid strobe one cycle after the request.

Lanes are little-endian: the low half of a register goes to the even byte address, and a word is named by the address of its low byte. Byte reads are zero-extended. A word request on an odd address never reaches the memory. Instead, the block raises an error strobe in the response cycle.

The memory is expected to take its address, enables and write data at a clock edge and to drive the read word throughout the following cycle.

Top module: `lane_mem_port`

## Requirements
- R1: For an access that goes to memory, `mem_addr` equals the byte address shifted right by one. Address bit 0 chooses the lane: 0 is bits 7:0 and 1 is bits 15:8.
- R2: `mem_be` is 2'b01 for a byte access at an even address, 2'b10 for a byte access at an odd address, and 2'b11 for a word access.
- R3: A byte write stores bits 7:0 of `req_wdata` into the addressed byte. The other byte of the same word keeps its value.
- R4: A word write stores all 16 bits. Bits 7:0 go to the even byte address and bits 15:8 go to the next, odd byte address.
- R5: A byte read returns the addressed byte in bits 7:0 of `rsp_rdata`, with bits 15:8 zero.
- R6: A word read returns the whole addressed word, with the even-address byte in bits 7:0.
- R7: `rsp_valid` is high for exactly the cycle after each accepted read. It stays low after writes and after idle cycles, and `rsp_rdata` is zero whenever `rsp_valid` is low.
- R8: A word request with address bit 0 set raises `mem_en` for no cycle, leaves memory unchanged and produces no `rsp_valid`. It drives `rsp_err` high for the cycle after the request.
- R9: While reset is held, and until the first request after it, `rsp_valid` and `rsp_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 0 = byte, 1 = 16-bit word |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 16 | Register value to write |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 11 | Word index |
| mem_be | output | 2 | Byte-lane enables |
| mem_wdata | output | 16 | Lane-steered write word |
| mem_rdata | input | 16 | Read word, valid the cycle after a read strobe |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | 16 | Formatted read value |
| rsp_err | output | 1 | Misaligned-request error strobe |

## Verification
Some properties are checked on every cycle: the lane-enable shape, the blocking of odd-address word requests from memory, the one-cycle timing of `rsp_valid` and `rsp_err`, and zero upper bits on byte reads. Whether the right byte lands in the right place can only be shown by the bench's scenarios against its own byte-level model of memory. Those scenarios cover partial writes that keep the neighbouring byte, misaligned writes that leave memory untouched, and reading the two halves of a word back as bytes.

// File: rtl/lmp_pkg.sv
package lmp_pkg;
  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_WORD = 1'b1
  } acc_size_e;
endpackage

// File: rtl/lmp_rst_sync.sv
module lmp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/lmp_decode.sv
module lmp_decode
  import lmp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES),
  localparam int WIDX_W = ADDR_W - LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  acc_size_e         req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [WIDX_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [LANE_W-1:0] lane,
  output logic              misal
);
  logic is_word;

  assign lane     = req_addr[LANE_W-1:0];
  assign mem_addr = req_addr[ADDR_W-1:LANE_W];
  assign is_word  = (req_size == SZ_WORD);

  always_comb begin
    misal  = req_valid && is_word && (lane != '0);
    mem_en = req_valid && !misal;
    mem_we = mem_en && req_write;
    if (is_word) mem_be = '1;
    else         mem_be = LANES'(1) << lane;
  end

  // Write steering: a byte store copies the low register byte into every
  // lane, and the enables pick the one that lands.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mem_wdata[g*8 +: 8] = is_word ? req_wdata[g*8 +: 8] : req_wdata[7:0];
  end

  p_misal_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_word && req_addr[0]) |-> !mem_en);
  p_word_all_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && is_word) |-> (mem_be == '1));
  p_byte_one_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !is_word) |-> ($countones(mem_be) == 1));
endmodule

// File: rtl/lmp_resp.sv
module lmp_resp
  import lmp_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_en,
  input  logic              mem_we,
  input  acc_size_e         req_size,
  input  logic [LANE_W-1:0] lane,
  input  logic              misal,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  logic              valid_q, valid_d;
  logic              err_q, err_d;
  logic              cap_en;
  logic [LANE_W-1:0] lane_q;
  acc_size_e         size_q;
  logic [7:0]        byte_sel;

  always_comb begin
    valid_d = mem_en && !mem_we;
    err_d   = misal;
    cap_en  = valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      lane_q  <= '0;
      size_q  <= SZ_BYTE;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
      if (cap_en) begin
        lane_q <= lane;
        size_q <= req_size;
      end
    end
  end

  assign byte_sel = mem_rdata[lane_q*8 +: 8];

  always_comb begin
    if (!valid_q)                rsp_rdata = '0;
    else if (size_q == SZ_WORD)  rsp_rdata = mem_rdata;
    else                         rsp_rdata = {{(DATA_W-8){1'b0}}, byte_sel};
  end

  assign rsp_valid = valid_q;
  assign rsp_err   = err_q;

  p_rsp_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> rsp_valid);
  p_no_rsp_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |=> !rsp_valid);
  p_err_follows_misal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    misal |=> (rsp_err && !rsp_valid));
  p_byte_zero_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_size == SZ_BYTE)) |-> (rsp_rdata[DATA_W-1:8] == '0));
endmodule

// File: rtl/lane_mem_port.sv
module lane_mem_port
  import lmp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES),
  localparam int WIDX_W = ADDR_W - LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [WIDX_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  logic              rst_int_n;
  acc_size_e         size_e;
  logic [LANE_W-1:0] lane;
  logic              misal;

  assign size_e = acc_size_e'(req_size);

  lmp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  lmp_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (size_e),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .lane      (lane),
    .misal     (misal)
  );

  lmp_resp #(.DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .req_size  (size_e),
    .lane      (lane),
    .misal     (misal),
    .mem_rdata (mem_rdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );
endmodule

// File: tb/lane_mem_port_tb_top.sv
`timescale 1ns/1ps
module lane_mem_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_size = 1'b0;
  logic [11:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        mem_en, mem_we;
  logic [10:0] mem_addr;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct { int due; bit v; bit e; logic [15:0] d; string tag; } exp_t;
  exp_t q[$];
  logic [7:0] refm [0:4095];
  logic [15:0] mem [0:2047];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lane_mem_port dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err));

  // Memory model: write by lane, registered read.
  always @(posedge clk) begin
    if (mem_en) begin
      for (int l = 0; l < 2; l++)
        if (mem_we && mem_be[l]) mem[mem_addr][l*8 +: 8] <= mem_wdata[l*8 +: 8];
      if (!mem_we) mem_rdata <= mem[mem_addr];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: issue one request, push the expected response, check the memory side.
  task automatic issue(input bit wr, input bit word, input logic [11:0] a,
                       input logic [15:0] wd, input string tag);
    exp_t it;
    bit mis;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = word; req_addr = a; req_wdata = wd;
    mis = word && a[0];
    it.due = cyc + 1; it.tag = tag;
    it.e = mis;
    it.v = !wr && !mis;
    it.d = '0;
    if (it.v) it.d = word ? {refm[a+1], refm[a]} : {8'h00, refm[a]};
    if (wr && !mis) begin
      if (word) begin refm[a] = wd[7:0]; refm[a+1] = wd[15:8]; end
      else refm[a] = wd[7:0];
    end
    q.push_back(it);
    #1;
    chk({tag, " R8 mem_en"}, mem_en, !mis);
    if (!mis) begin
      chk({tag, " R1 mem_addr"}, mem_addr, a >> 1);
      chk({tag, " R2 mem_be"}, mem_be, word ? 2'b11 : (a[0] ? 2'b10 : 2'b01));
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: compare every response as it falls due.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t it;
      it = q.pop_front();
      chk({it.tag, " R7 rsp_valid"}, rsp_valid, it.v);
      chk({it.tag, " R8 rsp_err"}, rsp_err, it.e);
      chk({it.tag, " R7 rsp_rdata"}, rsp_rdata, it.d);
    end
  end

  initial begin
    #(20 * 50000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 rsp_valid in reset", rsp_valid, 0);
    chk("R9 rsp_err in reset", rsp_err, 0);
    rst_n = 1'b1;
    idle(4);
    chk("R9 rsp_valid after reset", rsp_valid, 0);
    chk("R9 rsp_err after reset", rsp_err, 0);

    // R4 word store then R5/R6 readback as bytes and as a word
    issue(1, 1, 12'h010, 16'hA1B2, "R4 word write");
    issue(0, 0, 12'h010, 16'h0, "R5 even byte read");
    issue(0, 0, 12'h011, 16'h0, "R5 odd byte read");
    issue(0, 1, 12'h010, 16'h0, "R6 word read");

    // R3 partial writes keep the neighbouring byte
    issue(1, 1, 12'h020, 16'h1234, "R3 setup");
    issue(1, 0, 12'h021, 16'h77C3, "R3 odd byte write");
    issue(0, 1, 12'h020, 16'h0, "R3 readback odd");
    issue(1, 0, 12'h020, 16'hFF9E, "R3 even byte write");
    issue(0, 1, 12'h020, 16'h0, "R3 readback even");

    // R8 misaligned word accesses
    issue(1, 1, 12'h021, 16'hFFFF, "R8 misaligned write");
    issue(0, 1, 12'h020, 16'h0, "R8 memory unchanged");
    issue(0, 1, 12'h033, 16'h0, "R8 misaligned read");
    idle(2);

    // Pattern sweep with gaps, both lanes
    for (int k = 0; k < 16; k++)
      issue(1, 1, 12'h100 + 12'(2*k), 16'(k * 16'h1111 ^ 16'h0F0F), "R4 sweep write");
    for (int k = 0; k < 16; k++) begin
      issue(0, 0, 12'h100 + 12'(2*k) + 12'(k & 1), 16'h0, "R5 sweep byte read");
      if (k % 4 == 0) idle(1);
    end
    issue(1, 0, 12'hFFF, 16'h005A, "R3 top byte write");
    issue(0, 1, 12'hFFE, 16'h0, "R6 top word read");
    idle(3);
    chk("R7 queue drained", q.size(), 0);
    chk("R7 no response when idle", rsp_valid, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule